// File: doc/BRIEF.md
# Descriptor Ring Receive DMA Engine

This block drains a single fixed-address word source into system memory under the control of a chain of descriptors that it reads from that same memory. Each descriptor names a destination buffer, the local address of the source port, a byte count and a link to the next descriptor. Software normally builds a closed ring: the last descriptor links back to the first. Once started, the engine keeps running until it is aborted.

Transfers are paced by the source. The engine asserts `src_ready` only while it is inside a link and enabled. A word moves on every cycle where `src_valid` and `src_ready` are both high. The source must hold `src_data` stable until the word is accepted. `src_ready` may fall at any cycle, for example when `ctl_enable` is lowered, while a descriptor is being fetched, or after an abort. While the engine is inside a link, `src_addr` shows the local source address of that link, and that value stays the same for the whole link. Software tracks progress through `cur_addr`, the next destination address. It sees link completions through `link_done` and the latched `irq`.

Memory is reached through one request port. Writes complete in the cycle of the request. Read data is returned in the cycle after a read request.

Top module: `dring_dma`

## Requirements
- R1: After reset, `busy`, `halted`, `irq`, `link_done`, `mem_req` and `src_ready` are low, and `cur_addr` is 0.
- R2: A descriptor occupies four words at a 16-byte aligned address, at these offsets:
  - +0: destination start address
  - +4: local source address
  - +8: byte count
  - +12: next pointer

  The next descriptor is fetched from the next pointer with bits [3:0] cleared. Bit 1 of the next pointer is the interrupt-on-terminal-count flag. Bit 2 is the direction flag, and must be 1 for source-to-memory.
- R3: The effective byte count is the byte count limited to `MAX_BYTES` and then rounded down to a multiple of 4. The link is rejected when the effective count is 0 or direction bit 2 is clear. A rejected link makes `halted` high and keeps `src_ready` and `mem_req` low until an abort.
- R4: A word is accepted only in a cycle where `src_valid` and `src_ready` are both high. An accepted word is written to memory at `cur_addr`. `src_ready` is high only while the engine is inside a valid link.
- R5: `cur_addr` is loaded with the destination start address when a link begins. It advances by 4 with each accepted word.
- R6: `src_addr` equals the local source address of the current descriptor for the whole link.
- R7: After the last word of a link, the engine fetches the descriptor at the next pointer. A ring whose last link points back to the first wraps around and writes the first buffer again.
- R8: `link_done` pulses for exactly one cycle, in the cycle after the last word of every link. If the link's bit 1 is set, `irq` rises at the same time. `irq` then stays high until `ctl_irq_clr` is pulsed.
- R9: `ctl_start` starts the engine at `desc_base` only when the engine is idle and `ctl_enable` is high. `ctl_abort` returns the engine to idle from any state, so that `busy` and `src_ready` are low.
- R10: While `ctl_enable` is low, `src_ready` is low and `cur_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Run enable; low pauses transfers |
| ctl_start | input | 1 | Start pulse, taken only when idle |
| ctl_abort | input | 1 | Abort pulse, returns to idle |
| ctl_irq_clr | input | 1 | Clears the latched interrupt |
| desc_base | input | 32 | Address of the first descriptor |
| src_valid | input | 1 | Source word available |
| src_data | input | 32 | Source word |
| src_ready | output | 1 | Engine accepts a word this cycle |
| src_addr | output | 32 | Local source address of the current link |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| cur_addr | output | 32 | Next destination address |
| busy | output | 1 | Engine not idle |
| halted | output | 1 | Stopped on a rejected descriptor |
| link_done | output | 1 | One-cycle pulse at the end of each link |
| irq | output | 1 | Latched terminal-count interrupt |

## Verification
The hardest situation to reach is a ring wrap that happens while demand pacing and a pause are both in play. Each link must end on its exact final word, with the interrupt flag differing between links. The next descriptor fetch must then land back on the first buffer. The bench builds a three-link ring in its memory model with mixed interrupt flags. It feeds words one at a time, so that `src_valid` drops between words, and lowers `ctl_enable` in the middle of a link. It then pushes one more word to observe the wrap. A vector table of raw byte counts drives the size limiting and rejection cases.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W      = 32;
  localparam int DESC_WORDS  = 4;
  localparam int DESC_ALIGN  = 16;
  localparam int NP_IRQ_BIT  = 1;
  localparam int NP_DIR_BIT  = 2;
  localparam int BYTES_PER_W = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_HALT  = 2'd3
  } dring_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] mem_start;
    logic [WORD_W-1:0] loc_addr;
    logic [WORD_W-1:0] nbytes;
    logic [WORD_W-1:0] next;
  } dring_desc_t;
endpackage

// File: rtl/dring_desc_loader.sv
module dring_desc_loader
  import dring_pkg::*;
#(
  parameter int MAX_BYTES = 32'h10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              kill,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] rdata,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  output logic              done,
  output logic [WORD_W-1:0] mem_start,
  output logic [WORD_W-1:0] loc_addr,
  output logic [WORD_W-1:0] nbytes,
  output logic [WORD_W-1:0] next_ptr,
  output logic              irq_flag,
  output logic              bad
);
  localparam int IW = $clog2(DESC_WORDS);
  localparam logic [WORD_W-1:0] ALIGN_MASK = ~(WORD_W'(DESC_ALIGN - 1));
  localparam logic [WORD_W-1:0] WORD_MASK  = ~(WORD_W'(BYTES_PER_W - 1));

  logic              active;
  logic              pend;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     pend_idx;
  logic [WORD_W-1:0] ptr;
  dring_desc_t       d;
  logic [WORD_W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      pend     <= 1'b0;
      idx      <= '0;
      pend_idx <= '0;
      ptr      <= '0;
      done     <= 1'b0;
      d        <= '0;
    end else if (kill) begin
      active <= 1'b0;
      pend   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done     <= pend && (pend_idx == IW'(DESC_WORDS - 1));
      pend     <= active;
      pend_idx <= idx;
      if (go) begin
        active <= 1'b1;
        ptr    <= base;
        idx    <= '0;
      end else if (active) begin
        idx <= idx + 1'b1;
        if (idx == IW'(DESC_WORDS - 1)) active <= 1'b0;
      end
      if (pend) begin
        if (pend_idx == IW'(0))      d.mem_start <= rdata;
        else if (pend_idx == IW'(1)) d.loc_addr  <= rdata;
        else if (pend_idx == IW'(2)) d.nbytes    <= rdata;
        else                         d.next      <= rdata;
      end
    end
  end

  always_comb begin
    rd_req    = active;
    rd_addr   = ptr + WORD_W'({idx, 2'b00});
    lim       = (d.nbytes > WORD_W'(MAX_BYTES)) ? WORD_W'(MAX_BYTES) : d.nbytes;
    nbytes    = lim & WORD_MASK;
    mem_start = d.mem_start;
    loc_addr  = d.loc_addr;
    next_ptr  = d.next & ALIGN_MASK;
    irq_flag  = d.next[NP_IRQ_BIT];
    bad       = (nbytes == '0) || !d.next[NP_DIR_BIT];
  end
endmodule

// File: rtl/dring_xfer_ctr.sv
module dring_xfer_ctr
  import dring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] addr_in,
  input  logic [WORD_W-1:0] nbytes_in,
  input  logic              step,
  output logic [WORD_W-1:0] cur_addr,
  output logic              last
);
  logic [WORD_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= addr_in;
      remain   <= nbytes_in;
    end else if (step) begin
      cur_addr <= cur_addr + WORD_W'(BYTES_PER_W);
      remain   <= remain - WORD_W'(BYTES_PER_W);
    end
  end

  assign last = (remain == WORD_W'(BYTES_PER_W));
endmodule

// File: rtl/dring_irq_latch.sv
module dring_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/dring_dma.sv
module dring_dma
  import dring_pkg::*;
#(
  parameter int MAX_BYTES = 32'h10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_start,
  input  logic              ctl_abort,
  input  logic              ctl_irq_clr,
  input  logic [WORD_W-1:0] desc_base,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_data,
  output logic              src_ready,
  output logic [WORD_W-1:0] src_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] cur_addr,
  output logic              busy,
  output logic              halted,
  output logic              link_done,
  output logic              irq
);
  localparam logic [WORD_W-1:0] ALIGN_MASK = ~(WORD_W'(DESC_ALIGN - 1));

  dring_state_e      state;
  logic              ld_go;
  logic [WORD_W-1:0] ld_base;
  logic              ld_rd_req;
  logic [WORD_W-1:0] ld_rd_addr;
  logic              ld_done;
  logic [WORD_W-1:0] ld_mem_start;
  logic [WORD_W-1:0] ld_nbytes;
  logic [WORD_W-1:0] ld_next;
  logic              ld_irq_flag;
  logic              ld_bad;
  logic              ctr_last;
  logic              fire;
  logic              link_end;
  logic              ctr_load;
  logic              link_done_q;

  dring_desc_loader #(.MAX_BYTES(MAX_BYTES)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (ld_go),
    .kill     (ctl_abort),
    .base     (ld_base),
    .rdata    (mem_rdata),
    .rd_req   (ld_rd_req),
    .rd_addr  (ld_rd_addr),
    .done     (ld_done),
    .mem_start(ld_mem_start),
    .loc_addr (src_addr),
    .nbytes   (ld_nbytes),
    .next_ptr (ld_next),
    .irq_flag (ld_irq_flag),
    .bad      (ld_bad)
  );

  dring_xfer_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .addr_in  (ld_mem_start),
    .nbytes_in(ld_nbytes),
    .step     (fire),
    .cur_addr (cur_addr),
    .last     (ctr_last)
  );

  dring_irq_latch u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (link_end && ld_irq_flag),
    .clr  (ctl_irq_clr),
    .q    (irq)
  );

  always_comb begin
    src_ready = (state == ST_XFER) && ctl_enable;
    fire      = src_valid && src_ready;
    link_end  = fire && ctr_last;
    ctr_load  = (state == ST_FETCH) && ld_done && !ld_bad && !ctl_abort;
    ld_go     = !ctl_abort &&
                (((state == ST_IDLE) && ctl_start && ctl_enable) || link_end);
    ld_base   = (state == ST_IDLE) ? (desc_base & ALIGN_MASK) : ld_next;
    mem_req   = ld_rd_req || fire;
    mem_we    = fire;
    mem_addr  = fire ? cur_addr : ld_rd_addr;
    mem_wdata = src_data;
    busy      = (state != ST_IDLE);
    halted    = (state == ST_HALT);
    link_done = link_done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      link_done_q <= 1'b0;
    end else begin
      link_done_q <= link_end;
      if (ctl_abort) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE:  if (ld_go) state <= ST_FETCH;
          ST_FETCH: if (ld_done) state <= ld_bad ? ST_HALT : ST_XFER;
          ST_XFER:  if (link_end) state <= ST_FETCH;
          default:  state <= ST_HALT;
        endcase
      end
    end
  end
endmodule

// File: rtl/dring_dma_chk.sv
module dring_dma_chk
  import dring_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_enable,
  input logic              ctl_irq_clr,
  input logic              src_valid,
  input logic              src_ready,
  input logic [WORD_W-1:0] src_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] cur_addr,
  input logic              busy,
  input logic              halted,
  input logic              link_done,
  input logic              irq
);
  AST_READY_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (busy && !halted)); // R4
  AST_WRITE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (src_valid && src_ready && mem_addr == cur_addr)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> (link_done || cur_addr == $past(cur_addr) + 32'd4)); // R5
  AST_SRC_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> (link_done || $stable(src_addr))); // R6
  AST_LINK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    link_done |=> !link_done); // R8
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_irq_clr) |=> irq); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_req && !src_ready)); // R3
  AST_PAUSE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> !src_ready); // R10
endmodule

bind dring_dma dring_dma_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_enable (ctl_enable),
  .ctl_irq_clr(ctl_irq_clr),
  .src_valid  (src_valid),
  .src_ready  (src_ready),
  .src_addr   (src_addr),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .cur_addr   (cur_addr),
  .busy       (busy),
  .halted     (halted),
  .link_done  (link_done),
  .irq        (irq)
);

// File: tb/dring_dma_tb.sv
module dring_dma_tb;
  localparam int TB_MAX = 64;
  localparam int NV = 6;
  localparam logic [31:0] TV_SIZE [NV] = '{32'd16, 32'd7, 32'd3, 32'd0, 32'd100, 32'd64};
  localparam int TV_WORDS [NV] = '{4, 1, 0, 0, 16, 16};
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_enable = 1'b0, ctl_start = 1'b0, ctl_abort = 1'b0, ctl_irq_clr = 1'b0;
  logic [31:0] desc_base = '0;
  logic        src_valid = 1'b0;
  logic [31:0] src_data = '0;
  logic        src_ready, mem_req, mem_we, busy, halted, link_done, irq;
  logic [31:0] src_addr, mem_addr, mem_wdata, cur_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem_arr [0:127];
  int checks = 0, errors = 0, links = 0;

  always #5 clk = ~clk;

  dring_dma #(.MAX_BYTES(TB_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_start(ctl_start),
    .ctl_abort(ctl_abort), .ctl_irq_clr(ctl_irq_clr), .desc_base(desc_base),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .src_addr(src_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_addr(cur_addr),
    .busy(busy), .halted(halted), .link_done(link_done), .irq(irq)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem_arr[mem_addr[8:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem_arr[mem_addr[8:2]];
    if (link_done) links <= links + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int at, input logic [31:0] ms, input logic [31:0] la,
                          input logic [31:0] nb, input logic [31:0] np);
    mem_arr[at/4]     <= ms;
    mem_arr[at/4 + 1] <= la;
    mem_arr[at/4 + 2] <= nb;
    mem_arr[at/4 + 3] <= np;
  endtask

  task automatic fill_bufs();
    for (int i = 64; i < 128; i++) mem_arr[i] <= SENT;
  endtask

  task automatic pulse_start();
    @(negedge clk); ctl_start = 1'b1; @(negedge clk); ctl_start = 1'b0;
  endtask
  task automatic pulse_abort();
    @(negedge clk); ctl_abort = 1'b1; @(negedge clk); ctl_abort = 1'b0;
  endtask
  task automatic pulse_clr();
    @(negedge clk); ctl_irq_clr = 1'b1; @(negedge clk); ctl_irq_clr = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    src_valid = 1'b1; src_data = d;
    while (!src_ready) @(negedge clk);
    @(posedge clk); #1;
    src_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem_arr[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !halted && !irq && !link_done && !mem_req && !src_ready, "R1 outputs",
          {26'd0, busy, halted, irq, link_done, mem_req, src_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cur_addr == 32'd0, "R1 cur_addr", cur_addr, 32'd0);

    // Vector table: size limiting and rejection (R3), single self-linked descriptor
    ctl_enable = 1'b1;
    for (int v = 0; v < NV; v++) begin
      fill_bufs();
      put_desc(0, 32'h100, 32'hF00 + v, TV_SIZE[v], 32'h0000_0006);
      desc_base = 32'h0;
      @(negedge clk);
      pulse_start();
      if (TV_WORDS[v] == 0) begin
        repeat (10) @(negedge clk);
        check(halted && !src_ready, "R3 rejected size halts", {30'd0, halted, src_ready}, 32'd2);
        check(mem_arr[64] == SENT, "R3 no write when halted", mem_arr[64], SENT);
      end else begin
        for (int k = 0; k < TV_WORDS[v]; k++) push((v << 8) + k);
        repeat (2) @(negedge clk);
        check(irq, "R8 irq after link", {31'd0, irq}, 32'd1);
        check(mem_arr[64 + TV_WORDS[v] - 1] == ((v << 8) + TV_WORDS[v] - 1), "R3 last word",
              mem_arr[64 + TV_WORDS[v] - 1], (v << 8) + TV_WORDS[v] - 1);
        check(mem_arr[64 + TV_WORDS[v]] == SENT, "R3 count limit",
              mem_arr[64 + TV_WORDS[v]], SENT);
        check(src_addr == 32'hF00 + v, "R6 src_addr", src_addr, 32'hF00 + v);
        pulse_clr();
        @(negedge clk);
        check(!irq, "R8 irq cleared", {31'd0, irq}, 32'd0);
      end
      pulse_abort();
      @(negedge clk);
      check(!busy && !src_ready, "R9 abort to idle", {30'd0, busy, src_ready}, 32'd0);
    end

    // Direction flag clear is rejected (R3)
    fill_bufs();
    put_desc(0, 32'h100, 32'hA0, 32'd16, 32'h0000_0002);
    pulse_start();
    repeat (10) @(negedge clk);
    check(halted, "R3 direction bit clear halts", {31'd0, halted}, 32'd1);
    pulse_abort();

    // Start ignored while disabled (R9)
    ctl_enable = 1'b0;
    pulse_start();
    repeat (3) @(negedge clk);
    check(!busy, "R9 start ignored when disabled", {31'd0, busy}, 32'd0);
    ctl_enable = 1'b1;

    // Three-link ring with mixed interrupt flags (R2, R5, R7, R8, R10)
    fill_bufs();
    put_desc(32'h00, 32'h100, 32'hA0, 32'd8,  32'h0000_0016);
    put_desc(32'h10, 32'h140, 32'hB0, 32'd12, 32'h0000_0024);
    put_desc(32'h20, 32'h180, 32'hC0, 32'd4,  32'h0000_0006);
    desc_base = 32'h0000_0003;
    links = 0;
    @(negedge clk);
    pulse_start();
    push(32'h1111_0000);
    check(cur_addr == 32'h104, "R5 cur_addr step", cur_addr, 32'h104);
    push(32'h1111_0001);
    repeat (2) @(negedge clk);
    check(irq, "R8 irq on flagged link", {31'd0, irq}, 32'd1);
    pulse_clr();
    push(32'h2222_0000);
    check(src_addr == 32'hB0, "R6 second link src_addr", src_addr, 32'hB0);
    check(cur_addr == 32'h144, "R2 second buffer via next pointer", cur_addr, 32'h144);
    @(negedge clk); ctl_enable = 1'b0;
    repeat (5) @(negedge clk);
    check(!src_ready && cur_addr == 32'h144, "R10 pause", cur_addr, 32'h144);
    ctl_enable = 1'b1;
    push(32'h2222_0001);
    push(32'h2222_0002);
    repeat (2) @(negedge clk);
    check(!irq, "R2 no irq when bit 1 clear", {31'd0, irq}, 32'd0);
    check(mem_arr[82] == 32'h2222_0002, "R4 word lands at buffer", mem_arr[82], 32'h2222_0002);
    push(32'h3333_0000);
    repeat (2) @(negedge clk);
    check(irq, "R8 irq on third link", {31'd0, irq}, 32'd1);
    check(links == 3, "R8 one pulse per link", links, 32'd3);
    push(32'h4444_0000);
    check(mem_arr[64] == 32'h4444_0000, "R7 ring wraps to first buffer", mem_arr[64], 32'h4444_0000);
    check(mem_arr[65] == 32'h1111_0001, "R7 first buffer second word kept", mem_arr[65], 32'h1111_0001);

    // Valid held low: nothing accepted (R4)
    repeat (4) @(negedge clk);
    check(cur_addr == 32'h104, "R4 no accept without valid", cur_addr, 32'h104);
    pulse_abort();
    @(negedge clk);
    check(!busy && !src_ready, "R9 abort mid-link", {30'd0, busy, src_ready}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule